// File: doc/BRIEF.md
# User Interprocessor Interrupt Sender

This block carries out one user-level interprocessor interrupt send. A request brings a 64-bit table index together with the base address and size of the target table, two enable bits and the interrupt controller addressing mode. The block checks the enables and the index bound. It then reads one 16-byte target entry and checks its valid bit and reserved bits. Under a held lock it reads the posted-interrupt descriptor that the entry points to, checks the descriptor's reserved bits, posts the request bit chosen by the entry's user vector, and writes the descriptor back.

The notification decision comes from two descriptor flags: suppress and outstanding. When both are clear, the outstanding flag is set and an ordinary IPI request leaves the block. The request carries the descriptor's notification vector and a destination whose format follows the addressing mode. Each accepted request ends in exactly one single-cycle pulse: done, a general-protection fault or an invalid-opcode fault. Memory is reached through a request/acknowledge port with a lock output.

Top module: `uipi_sender`

## Requirements
- R1: When `feat_en` or `tt_en` is 0, a request ends with a `fault_ud` pulse one cycle later and makes no memory transaction.
- R2: When `req_index` is greater than `tbl_size`, the request ends with a `fault_gp` pulse and makes no memory transaction. An index equal to the size proceeds.
- R3: The first transaction is an unlocked read at address `tbl_base + req_index*16`. While `mem_req` waits for `mem_ack`, the address and the write flag stay stable.
- R4: An entry with bit 0 (valid) clear, or any of bits 7:1 set, ends the request with `fault_gp` after that single read.
- R5: The descriptor is read at the address in entry bits 127:64 with `mem_lock` high. If descriptor bits 15:2 or 31:24 are nonzero, the request ends with `fault_gp`, the lock drops, and no write is made.
- R6: The written descriptor equals the read descriptor with bit 64+UV set, where UV is entry bits 13:8. Entry bits 15:14 are ignored.
- R7: When descriptor bit 1 (suppress) and bit 0 (outstanding) are both 0, the written bit 0 is 1 and `ipi_valid` pulses together with `done`. Otherwise bit 0 is unchanged and no IPI is requested.
- R8: The write-back is made to the descriptor address with `mem_lock` high. The lock is low in the cycle that `done` pulses.
- R9: `ipi_vector` is descriptor bits 23:16. `ipi_dest` is descriptor bits 63:32 when `apic_x2` was 1 at the request; otherwise it is bits 47:40 zero-extended.
- R10: After reset `busy`, `mem_req`, `mem_lock` and all pulse outputs are 0. `busy` is high from acceptance until completion, requests made while busy are ignored, and at most one of `done`, `fault_gp` and `fault_ud` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a send (taken only when not busy) |
| req_index | input | 64 | Target table index |
| tbl_base | input | 64 | Target table base address |
| tbl_size | input | 64 | Largest permitted index |
| feat_en | input | 1 | Feature enable control bit |
| tt_en | input | 1 | Target table enable bit |
| apic_x2 | input | 1 | 1: 32-bit destination addressing, 0: 8-bit |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_lock | output | 1 | Lock held across descriptor read and write |
| mem_addr | output | 64 | Byte address of the 16-byte line |
| mem_wdata | output | 128 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge of the request |
| mem_rdata | input | 128 | Read data, valid with `mem_ack` |
| done | output | 1 | Successful completion pulse |
| fault_gp | output | 1 | General-protection fault pulse |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| ipi_valid | output | 1 | IPI request pulse |
| ipi_vector | output | 8 | IPI vector |
| ipi_dest | output | 32 | IPI destination ID |

## Verification
Some properties are checked on every cycle. These are the lock being held for any write, the lock being released on completion and on a descriptor fault, a stable request while it waits, mutually exclusive outcome pulses, IPI pulses only alongside done, and a zero upper destination in 8-bit mode. The bench scenarios show the parts that need a memory image. These include the entry address arithmetic, the bound and enable checks that make no access, each reserved-bit fault and the exact posted bit for every user vector. They also cover the notify decision for all flag pairs, the destination formatting, and requests being ignored while busy.

// File: rtl/uipi_pkg.sv
package uipi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ENTRY, ST_DESC, ST_WRITE} uipi_state_e;

  // target entry fields
  localparam int ENT_VALID  = 0;
  localparam int ENT_RSV_LO = 1;
  localparam int ENT_RSV_HI = 7;
  localparam int ENT_UV_LO  = 8;
  localparam int ENT_PTR_LO = 64;

  // descriptor fields
  localparam int DSC_OUT    = 0;
  localparam int DSC_SUP    = 1;
  localparam int DSC_RA_LO  = 2;
  localparam int DSC_RA_HI  = 15;
  localparam int DSC_VEC_LO = 16;
  localparam int DSC_RB_LO  = 24;
  localparam int DSC_RB_HI  = 31;
  localparam int DSC_DST_LO = 32;
  localparam int DSC_PIR_LO = 64;
endpackage

// File: rtl/uipi_entry_check.sv
module uipi_entry_check
  import uipi_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int UV_W   = 6
) (
  input  logic [ENT_UV_LO+UV_W-1:0] ent_lo,
  input  logic [ADDR_W-1:0]         ent_ptr,
  output logic                      ok,
  output logic [UV_W-1:0]           uv,
  output logic [ADDR_W-1:0]         desc_addr
);
  always_comb begin
    ok        = ent_lo[ENT_VALID] && (ent_lo[ENT_RSV_HI:ENT_RSV_LO] == '0);
    uv        = ent_lo[ENT_UV_LO +: UV_W];
    desc_addr = ent_ptr;
  end
endmodule

// File: rtl/uipi_desc_update.sv
module uipi_desc_update
  import uipi_pkg::*;
#(
  parameter int LINE_W = 128,
  parameter int UV_W   = 6,
  parameter int VEC_W  = 8,
  parameter int DST_W  = 32
) (
  input  logic [LINE_W-1:0] line,
  input  logic [UV_W-1:0]   uv,
  output logic              ok,
  output logic              notify,
  output logic [LINE_W-1:0] new_line,
  output logic [VEC_W-1:0]  nvec,
  output logic [DST_W-1:0]  ndst
);
  localparam int PIR_N = 1 << UV_W;

  logic [PIR_N-1:0] pir_old, pir_new;
  assign pir_old = line[DSC_PIR_LO +: PIR_N];

  for (genvar i = 0; i < PIR_N; i++) begin : g_post
    assign pir_new[i] = pir_old[i] | (uv == UV_W'(i));
  end

  always_comb begin
    ok       = (line[DSC_RA_HI:DSC_RA_LO] == '0) && (line[DSC_RB_HI:DSC_RB_LO] == '0);
    notify   = !line[DSC_SUP] && !line[DSC_OUT];
    new_line = {pir_new, line[DSC_PIR_LO-1:DSC_OUT+1], line[DSC_OUT] | notify};
    nvec     = line[DSC_VEC_LO +: VEC_W];
    ndst     = line[DSC_DST_LO +: DST_W];
  end
endmodule

// File: rtl/uipi_ipi_format.sv
module uipi_ipi_format #(
  parameter int DST_W    = 32,
  parameter int LEG_LO   = 8,
  parameter int LEG_W    = 8
) (
  input  logic             wide_mode,
  input  logic [DST_W-1:0] ndst,
  output logic [DST_W-1:0] dest
);
  logic [DST_W-1:0] legacy;
  if (DST_W > LEG_W) begin : g_ext
    assign legacy = {{(DST_W-LEG_W){1'b0}}, ndst[LEG_LO +: LEG_W]};
  end else begin : g_nrw
    assign legacy = ndst[LEG_LO +: DST_W];
  end
  assign dest = wide_mode ? ndst : legacy;
endmodule

// File: rtl/uipi_sender.sv
module uipi_sender
  import uipi_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 64,
  parameter int LINE_W = 128,
  parameter int UV_W   = 6,
  parameter int VEC_W  = 8,
  parameter int DST_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  tbl_size,
  input  logic              feat_en,
  input  logic              tt_en,
  input  logic              apic_x2,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault_gp,
  output logic              fault_ud,
  output logic              ipi_valid,
  output logic [VEC_W-1:0]  ipi_vector,
  output logic [DST_W-1:0]  ipi_dest
);
  localparam int ENT_SHIFT = $clog2(LINE_W / 8);

  uipi_state_e       state;
  logic [UV_W-1:0]   uv_q;
  logic              x2_q, notify_q;
  logic [VEC_W-1:0]  nvec_q;
  logic [DST_W-1:0]  ndst_q;

  logic [ADDR_W-1:0] entry_addr;
  logic              ent_ok, dsc_ok, dsc_notify;
  logic [UV_W-1:0]   ent_uv;
  logic [ADDR_W-1:0] ent_daddr;
  logic [LINE_W-1:0] dsc_new;
  logic [VEC_W-1:0]  dsc_vec;
  logic [DST_W-1:0]  dsc_dst, fmt_dest;

  assign entry_addr = tbl_base + (ADDR_W'(req_index) << ENT_SHIFT);
  assign busy       = (state != ST_IDLE);

  uipi_entry_check #(.ADDR_W(ADDR_W), .UV_W(UV_W)) u_ent (
    .ent_lo    (mem_rdata[ENT_UV_LO+UV_W-1:0]),
    .ent_ptr   (mem_rdata[ENT_PTR_LO +: ADDR_W]),
    .ok        (ent_ok),
    .uv        (ent_uv),
    .desc_addr (ent_daddr)
  );

  uipi_desc_update #(.LINE_W(LINE_W), .UV_W(UV_W), .VEC_W(VEC_W), .DST_W(DST_W)) u_dsc (
    .line     (mem_rdata),
    .uv       (uv_q),
    .ok       (dsc_ok),
    .notify   (dsc_notify),
    .new_line (dsc_new),
    .nvec     (dsc_vec),
    .ndst     (dsc_dst)
  );

  uipi_ipi_format #(.DST_W(DST_W)) u_fmt (
    .wide_mode (x2_q),
    .ndst      (ndst_q),
    .dest      (fmt_dest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_lock   <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      fault_gp   <= 1'b0;
      fault_ud   <= 1'b0;
      ipi_valid  <= 1'b0;
      ipi_vector <= '0;
      ipi_dest   <= '0;
      uv_q       <= '0;
      x2_q       <= 1'b0;
      notify_q   <= 1'b0;
      nvec_q     <= '0;
      ndst_q     <= '0;
    end else begin
      done      <= 1'b0;
      fault_gp  <= 1'b0;
      fault_ud  <= 1'b0;
      ipi_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          x2_q <= apic_x2;
          if (!(feat_en && tt_en)) begin
            fault_ud <= 1'b1;
          end else if (req_index > tbl_size) begin
            fault_gp <= 1'b1;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_lock <= 1'b0;
            mem_addr <= entry_addr;
            state    <= ST_ENTRY;
          end
        end
        ST_ENTRY: if (mem_ack) begin
          if (!ent_ok) begin
            mem_req  <= 1'b0;
            fault_gp <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            uv_q     <= ent_uv;
            mem_addr <= ent_daddr;
            mem_lock <= 1'b1;
            state    <= ST_DESC;
          end
        end
        ST_DESC: if (mem_ack) begin
          if (!dsc_ok) begin
            mem_req  <= 1'b0;
            mem_lock <= 1'b0;
            fault_gp <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            mem_we    <= 1'b1;
            mem_wdata <= dsc_new;
            notify_q  <= dsc_notify;
            nvec_q    <= dsc_vec;
            ndst_q    <= dsc_dst;
            state     <= ST_WRITE;
          end
        end
        ST_WRITE: if (mem_ack) begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          mem_lock  <= 1'b0;
          done      <= 1'b1;
          ipi_valid <= notify_q;
          if (notify_q) begin
            ipi_vector <= nvec_q;
            ipi_dest   <= fmt_dest;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  lock_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_lock);
  // R8
  lock_free_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_lock && !mem_req);
  // R5
  lock_free_fault_chk: assert property (@(posedge clk) disable iff (rst)
    fault_gp |-> !mem_lock);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fault_gp, fault_ud}));
  // R7
  ipi_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    ipi_valid |-> done);
  // R1
  ud_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fault_ud |-> (!busy && !mem_req));
  // R9
  narrow_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (ipi_valid && !x2_q) |-> (ipi_dest[DST_W-1:8] == '0));
endmodule

// File: tb/uipi_sender_bench.sv
module uipi_sender_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         req_valid = 1'b0;
  logic [63:0]  req_index = '0, tbl_base = 64'h40, tbl_size = 64'd5;
  logic         feat_en = 1'b1, tt_en = 1'b1, apic_x2 = 1'b0;
  logic         busy, mem_req, mem_we, mem_lock, mem_ack;
  logic [63:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic         done, fault_gp, fault_ud, ipi_valid;
  logic [7:0]   ipi_vector;
  logic [31:0]  ipi_dest;

  uipi_sender u_uipi_sender (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .tbl_base(tbl_base), .tbl_size(tbl_size), .feat_en(feat_en), .tt_en(tt_en),
    .apic_x2(apic_x2), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault_gp(fault_gp),
    .fault_ud(fault_ud), .ipi_valid(ipi_valid), .ipi_vector(ipi_vector),
    .ipi_dest(ipi_dest));

  // memory model: one wait cycle, then a one-cycle acknowledge
  logic [127:0] mem [0:63];
  int           txn_total;
  int           wcnt;
  logic [63:0]  log_addr  [0:7];
  logic         log_we    [0:7];
  logic         log_lock  [0:7];
  logic [127:0] log_wdata [0:7];

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_rdata <= '0; txn_total <= 0; wcnt <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt == 1) begin
          mem_ack <= 1'b1;
          wcnt <= 0;
          mem_rdata <= mem[mem_addr[9:4]];
          log_addr[txn_total % 8]  <= mem_addr;
          log_we[txn_total % 8]    <= mem_we;
          log_lock[txn_total % 8]  <= mem_lock;
          log_wdata[txn_total % 8] <= mem_wdata;
          txn_total <= txn_total + 1;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  int checks = 0, failures = 0, cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // results of the last operation
  bit g_done, g_gp, g_ud, g_ipi, g_lock, g_timeout;
  logic [7:0]  g_vec;
  logic [31:0] g_dst;
  int          g_first, g_ntxn;

  task automatic run_op(input logic [63:0] idx, input int extra_req);
    bit fin;
    @(negedge clk);
    g_first = txn_total;
    req_index = idx;
    req_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k < extra_req; k++) begin
      req_index = 64'd7;
      chk(busy == 1'b1, "R10 busy during op", 128'(busy), 128'd1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    fin = (done || fault_gp || fault_ud);
    for (int t = 0; t < 60 && !fin; t++) begin
      @(negedge clk);
      fin = (done || fault_gp || fault_ud);
    end
    g_timeout = !fin;
    g_done = done; g_gp = fault_gp; g_ud = fault_ud; g_ipi = ipi_valid;
    g_vec = ipi_vector; g_dst = ipi_dest; g_lock = mem_lock;
    g_ntxn = txn_total - g_first;
    if (g_timeout) chk(1'b0, "R10 operation timeout", 0, 1);
    @(negedge clk);
    chk(!busy && !done && !fault_gp && !fault_ud, "R10 idle after outcome", 128'(busy), 0);
  endtask

  function automatic logic [127:0] mk_entry(input bit v, input logic [6:0] rsv,
                                            input logic [7:0] uvf, input logic [63:0] dp);
    return {dp, 48'h0, uvf, rsv, v};
  endfunction

  localparam logic [63:0] DADDR = 64'h300;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !mem_req && !mem_lock && !done && !fault_gp && !fault_ud && !ipi_valid,
        "R10 reset outputs", {busy, mem_req, mem_lock, done, fault_gp, fault_ud, ipi_valid}, 0);

    // R1: enable combinations
    for (int f = 0; f < 3; f++) begin
      feat_en = f[0]; tt_en = f[1];
      run_op(64'd0, 0);
      chk(g_ud && !g_gp && !g_done, "R1 ud fault", {g_ud, g_gp, g_done}, 3'b100);
      chk(g_ntxn == 0, "R1 no memory access", g_ntxn, 0);
    end
    feat_en = 1'b1; tt_en = 1'b1;

    // R2: index bound sweep, all entries valid
    for (int i = 0; i < 12; i++) mem[4 + i] = mk_entry(1'b1, 7'h0, 8'd3, DADDR);
    for (int i = 0; i < 9; i++) begin
      logic [63:0] ix;
      ix = (i == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'(i);
      mem[48] = {64'h0, 32'h0000_1200, 8'h0, 8'h21, 16'h0};
      run_op(ix, 0);
      if (ix > 64'd5) begin
        chk(g_gp && !g_done, "R2 index above size faults", {g_gp, g_done}, 2'b10);
        chk(g_ntxn == 0, "R2 no access on bound fault", g_ntxn, 0);
      end else begin
        chk(g_done && !g_gp, "R2 index within size proceeds", {g_gp, g_done}, 2'b01);
        chk(log_addr[g_first % 8] == tbl_base + 64'(i) * 16 && !log_we[g_first % 8]
            && !log_lock[g_first % 8], "R3 entry address unlocked read",
            log_addr[g_first % 8], tbl_base + 64'(i) * 16);
      end
    end
    tbl_size = 64'd0;
    run_op(64'd0, 0);
    chk(g_done, "R2 size zero index zero", g_done, 1);
    tbl_size = 64'd5;

    // R4: invalid entries
    for (int b = 0; b < 8; b++) begin
      mem[4] = (b == 0) ? mk_entry(1'b0, 7'h0, 8'd1, DADDR)
                        : mk_entry(1'b1, 7'(1 << (b - 1)), 8'd1, DADDR);
      run_op(64'd0, 0);
      chk(g_gp && !g_done, "R4 bad entry faults", {g_gp, g_done}, 2'b10);
      chk(g_ntxn == 1, "R4 single read only", g_ntxn, 1);
    end

    // R5: descriptor reserved bits
    mem[4] = mk_entry(1'b1, 7'h0, 8'd5, DADDR);
    for (int b = 2; b < 32; b++) begin
      if (b >= 16 && b < 24) continue;
      mem[48] = 128'(1) << b;
      run_op(64'd0, 0);
      chk(g_gp && !g_done, "R5 reserved descriptor faults", {g_gp, g_done}, 2'b10);
      chk(g_ntxn == 2 && log_lock[(g_first + 1) % 8] && !log_we[(g_first + 1) % 8]
          && log_addr[(g_first + 1) % 8] == DADDR, "R5 locked read no write", g_ntxn, 2);
      chk(!g_lock, "R5 lock released", g_lock, 0);
    end

    // R6 R7 R8 R9: sweep user vector, flags and mode
    for (int uv = 0; uv < 64; uv++) begin
      for (int fl = 0; fl < 4; fl++) begin
        for (int md = 0; md < 2; md++) begin
          logic [127:0] d0, dx;
          logic [31:0]  dst;
          logic [7:0]   nv;
          bit           nt;
          int           ix;
          ix  = uv % 6;
          nv  = 8'(uv * 3 + 1);
          dst = 32'h1234_0000 + 32'(uv * 257);
          d0  = {64'h0000_0001_0000_0010, dst, 8'h0, nv, 14'h0, fl[1], fl[0]};
          mem[4 + ix] = mk_entry(1'b1, 7'h0, {(uv % 2 == 1) ? 2'b11 : 2'b00, 6'(uv)}, DADDR);
          mem[48] = d0;
          apic_x2 = md[0];
          run_op(64'(ix), 0);
          nt = (fl == 0);
          dx = d0 | (128'(1) << (64 + uv)) | 128'(nt);
          chk(g_done, "R6 completes", g_done, 1);
          chk(g_ntxn == 3, "R8 three transactions", g_ntxn, 3);
          chk(log_wdata[(g_first + 2) % 8] == dx, "R6 R7 written descriptor",
              log_wdata[(g_first + 2) % 8], dx);
          chk(log_we[(g_first + 2) % 8] && log_lock[(g_first + 2) % 8]
              && log_addr[(g_first + 2) % 8] == DADDR, "R8 locked write",
              log_addr[(g_first + 2) % 8], DADDR);
          chk(!g_lock, "R8 lock low at done", g_lock, 0);
          chk(g_ipi == nt, "R7 notify decision", g_ipi, nt);
          if (nt) begin
            chk(g_vec == nv, "R9 vector", g_vec, nv);
            chk(g_dst == (md ? dst : {24'h0, dst[15:8]}), "R9 destination", g_dst,
                md ? dst : {24'h0, dst[15:8]});
          end
        end
      end
    end

    // R10: requests while busy are ignored
    apic_x2 = 1'b0;
    mem[4] = mk_entry(1'b1, 7'h0, 8'd9, DADDR);
    mem[11] = mk_entry(1'b0, 7'h0, 8'd0, DADDR);
    mem[48] = {64'h0, 32'h0000_AB00, 8'h0, 8'h44, 16'h0};
    run_op(64'd0, 2);
    chk(g_done && g_ntxn == 3, "R10 busy request ignored", g_ntxn, 3);
    repeat (10) @(negedge clk);
    chk(!busy && txn_total == g_first + 3, "R10 no second operation", txn_total - g_first, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule